// File: doc/BRIEF.md
# Opcode-Dispatch Microsequencer

This block steers a microcoded byte-code interpreter. It keeps a micro-PC that addresses an external control store, and it reads that store asynchronously from the registered micro-PC. Every control word names its successor explicitly, so no address is formed by incrementing. A dispatch bit in the word ORs the opcode byte held in the byte register into the successor field. A handler whose first word sits at an address equal to its opcode value is therefore reached in a single step. The remaining words of each handler live in unused control-store locations and are chained through their successor fields.

The block also owns the program counter and the byte register. Two strobes in the control word request a program-counter step and a byte fetch. A fetch reads a byte-wide memory that returns its data in the cycle after the request. The byte register captures that data at the end of the same cycle, so the byte can be used from the second microinstruction after the request onward. The main-loop word sets all three bits. It moves the counter past the current opcode, requests the following byte, and branches on the opcode that is already in the byte register.

After reset, a two-cycle boot phase loads the byte at address 0 into the byte register, so the first dispatch acts on a valid opcode.

Top module: `ucode_dispatch_seq`

## Requirements
- R1: The control word is 12 bits wide: bits [8:0] hold the successor address, bit 9 is dispatch, bit 10 is PC step and bit 11 is fetch. When a word executes with dispatch clear, the next uAddr equals bits [8:0].
- R2: When a word executes with dispatch set, the next uAddr equals bits [8:0] ORed with the zero-extended byte that mbr holds at the start of that cycle. A byte returning from memory during that cycle has no effect on the target.
- R3: When an executing word has PC step set, pc increases by exactly 1 at the end of the cycle. Otherwise pc keeps its value.
- R4: When an executing word has fetch set, memRd is high in that cycle. memAddr is then pc+1 if PC step is also set, and pc otherwise. With fetch clear, memRd stays low.
- R5: The byte that memory returns on memRdData in the cycle after a request is present on mbr from the second cycle after the request.
- R6: mbr changes only as a result of a request made two cycles earlier.
- R7: While rstN is low: uAddr is 0x100, pc is 0, uExec is 0, and memRd is high with memAddr 0. In the first cycle after release no word executes. In the second cycle uExec is still 0 and uWord is ignored. From the third cycle, words execute at 0x100 with mbr holding the byte at address 0.
- R8: With program bytes 0x00, 0x60, 0x00 at addresses 0 to 2 and a three-word handler at 0x060, the executed uAddr sequence begins 0x100, 0x000, 0x100, 0x060, 0x1B1, 0x1B2, 0x100, 0x000, 0x100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| uAddr | output | 9 | Registered micro-PC, control-store read address |
| uWord | input | 12 | Control word at uAddr |
| uExec | output | 1 | High when uWord is being executed this cycle |
| memAddr | output | 16 | Byte read address |
| memRd | output | 1 | Byte read request |
| memRdData | input | 8 | Read data, valid the cycle after the request |
| pc | output | 16 | Program counter |
| mbr | output | 8 | Byte register holding the current opcode or operand |

## Verification
The bench builds the block with its default parameters: a 9-bit micro-PC, 8-bit opcodes, a 16-bit program counter and the main loop at 0x100. With these values, an odd-multiplier byte stream beyond the first three addresses makes every one of the 256 opcode values appear as a dispatch source several times within one run. The bench's control store adds a multi-word handler placed in gaps, a fetch without a step, a step without a fetch, back-to-back fetches, and a second-level dispatch into the upper page. Each of these is compared cycle by cycle against a model built from the requirements, and the comparison is repeated after a reset in mid-run.

// File: rtl/udisp_pkg.sv
package udisp_pkg;
  localparam int UADDR_W = 9;
  localparam int OP_W    = 8;
  localparam int UWORD_W = UADDR_W + 3;

  // Control word layout, MSB first: fetch, pcStep, dispatch, nextAddr.
  typedef struct packed {
    logic               fetch;
    logic               pcStep;
    logic               dispatch;
    logic [UADDR_W-1:0] nextAddr;
  } uword_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic pcStep;
    logic fetch;
    logic bootRd;
  } strobe_t;

  typedef enum logic [1:0] {
    PH_BOOT_REQ  = 2'd0,
    PH_BOOT_WAIT = 2'd1,
    PH_RUN       = 2'd2
  } phase_t;
endpackage

// File: rtl/udisp_ctrl.sv
module udisp_ctrl
  import udisp_pkg::*;
#(
  parameter logic [UADDR_W-1:0] MAIN_ADDR = 9'h100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [UWORD_W-1:0] uWord,
  input  logic [OP_W-1:0]    mbr,
  output logic [UADDR_W-1:0] uAddr,
  output logic               uExec,
  output strobe_t            strobe
);
  phase_t             phaseQ;
  logic [UADDR_W-1:0] uPcQ;
  logic [UADDR_W-1:0] opExt;
  logic [UADDR_W-1:0] targetAddr;
  uword_t             word;

  assign word = uword_t'(uWord);

  generate
    if (UADDR_W > OP_W) begin : g_widen
      assign opExt = {{(UADDR_W-OP_W){1'b0}}, mbr};
    end else begin : g_trim
      assign opExt = mbr[UADDR_W-1:0];
    end
  endgenerate

  // Successor: explicit field, with the held opcode ORed in on dispatch.
  assign targetAddr = word.dispatch ? (word.nextAddr | opExt) : word.nextAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_BOOT_REQ;
      uPcQ   <= MAIN_ADDR;
    end else begin
      unique case (phaseQ)
        PH_BOOT_REQ:  phaseQ <= PH_BOOT_WAIT;
        PH_BOOT_WAIT: phaseQ <= PH_RUN;
        default:      uPcQ   <= targetAddr;
      endcase
    end
  end

  assign uAddr         = uPcQ;
  assign uExec         = (phaseQ == PH_RUN);
  assign strobe.bootRd = (phaseQ == PH_BOOT_REQ);
  assign strobe.pcStep = uExec & word.pcStep;
  assign strobe.fetch  = uExec & word.fetch;

  // R1: a plain word hands over to its successor field
  p_next_field_r1: assert property (@(posedge clk) disable iff (!rstN)
    (uExec && !uWord[UADDR_W]) |=> (uAddr == $past(uWord[UADDR_W-1:0])));

  // R2: a dispatch word ORs in the opcode held at the start of the cycle
  p_dispatch_or_r2: assert property (@(posedge clk) disable iff (!rstN)
    (uExec && uWord[UADDR_W]) |=> (uAddr == ($past(uWord[UADDR_W-1:0]) | $past(opExt))));

  // R7: no word executes while the boot phase runs, and the micro-PC stays put
  p_boot_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !uExec |=> $stable(uAddr));
endmodule

// File: rtl/udisp_dp.sv
module udisp_dp
  import udisp_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobe,
  input  logic [OP_W-1:0] memRdData,
  output logic [PC_W-1:0] memAddr,
  output logic            memRd,
  output logic [PC_W-1:0] pc,
  output logic [OP_W-1:0] mbr
);
  logic [PC_W-1:0] pcQ;
  logic [PC_W-1:0] pcNext;
  logic [OP_W-1:0] mbrQ;
  logic            pendQ;

  assign pcNext  = pcQ + PC_W'(1);
  assign memRd   = strobe.bootRd | strobe.fetch;
  assign memAddr = strobe.bootRd ? '0 : (strobe.pcStep ? pcNext : pcQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= '0;
      mbrQ  <= '0;
      pendQ <= 1'b0;
    end else begin
      pendQ <= memRd;
      if (pendQ)         mbrQ <= memRdData;
      if (strobe.pcStep) pcQ  <= pcNext;
    end
  end

  assign pc  = pcQ;
  assign mbr = mbrQ;

  // R3: the counter moves by exactly one on a step and holds otherwise
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pcStep |=> (pc == $past(pc) + PC_W'(1)));
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pcStep |=> $stable(pc));

  // R5: the byte returned the cycle after a request lands in mbr
  p_mbr_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(memRd) |=> (mbr == $past(memRdData)));

  // R6: without a request two cycles back, mbr keeps its value
  p_mbr_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(memRd) |=> $stable(mbr));
endmodule

// File: rtl/ucode_dispatch_seq.sv
module ucode_dispatch_seq
  import udisp_pkg::*;
#(
  parameter int                 PC_W      = 16,
  parameter logic [UADDR_W-1:0] MAIN_ADDR = 9'h100
) (
  input  logic               clk,
  input  logic               rstN,
  output logic [UADDR_W-1:0] uAddr,
  input  logic [UWORD_W-1:0] uWord,
  output logic               uExec,
  output logic [PC_W-1:0]    memAddr,
  output logic               memRd,
  input  logic [OP_W-1:0]    memRdData,
  output logic [PC_W-1:0]    pc,
  output logic [OP_W-1:0]    mbr
);
  strobe_t strobe;

  udisp_ctrl #(.MAIN_ADDR(MAIN_ADDR)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .uWord  (uWord),
    .mbr    (mbr),
    .uAddr  (uAddr),
    .uExec  (uExec),
    .strobe (strobe)
  );

  udisp_dp #(.PC_W(PC_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memRd     (memRd),
    .pc        (pc),
    .mbr       (mbr)
  );

  // R4: a fetch request only ever comes from boot or an executing fetch word
  p_fetch_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && uExec) |-> uWord[UADDR_W+2]);
endmodule

// File: tb/ucode_dispatch_seq_tb_top.sv
`timescale 1ns/1ps
module ucode_dispatch_seq_tb_top;
  localparam logic [8:0] MAIN = 9'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  uAddr;
  logic [11:0] uWord;
  logic        uExec;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  memRdData = 8'h00;
  logic [15:0] pc;
  logic [7:0]  mbr;

  always #2.5 clk = ~clk;

  ucode_dispatch_seq dut_i (
    .clk(clk), .rstN(rstN), .uAddr(uAddr), .uWord(uWord), .uExec(uExec),
    .memAddr(memAddr), .memRd(memRd), .memRdData(memRdData), .pc(pc), .mbr(mbr)
  );

  // Control store: {fetch, pcStep, dispatch, next[8:0]}
  function automatic logic [11:0] csWord(input logic [8:0] a);
    case (a)
      9'h100:  return {3'b111, 9'h000};   // main loop
      9'h057:  return {3'b000, 9'h1A0};   // three-word handler in gaps
      9'h1A0:  return {3'b000, 9'h1A4};
      9'h1A4:  return {3'b100, MAIN};     // fetch without step
      9'h060:  return {3'b000, 9'h1B1};
      9'h1B1:  return {3'b000, 9'h1B2};
      9'h1B2:  return {3'b000, MAIN};
      9'h059:  return {3'b001, 9'h100};   // second-level dispatch
      9'h033:  return {3'b010, MAIN};     // step without fetch
      9'h044:  return {3'b110, MAIN};     // back-to-back fetch
      default: return {3'b000, MAIN};
    endcase
  endfunction

  function automatic logic [7:0] memByte(input logic [15:0] a);
    if (a == 16'd1) return 8'h60;
    if (a == 16'd0 || a == 16'd2) return 8'h00;
    return 8'(a * 16'd73 + 16'd11);
  endfunction

  assign uWord = csWord(uAddr);
  always_ff @(posedge clk) if (memRd) memRdData <= memByte(memAddr);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [8:0]  refUpc;
  logic [15:0] refPc;
  logic [7:0]  refMbr;
  int          refBoot;
  logic        refReqV;
  logic [15:0] refReqA;
  int          execIdx;
  logic [8:0]  seqExp [9];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic refReset();
    refUpc = MAIN; refPc = '0; refMbr = '0; refBoot = 2;
    refReqV = 1'b0; refReqA = '0; execIdx = 0;
  endtask

  task automatic compare();
    logic [11:0] w;
    logic expRd;
    w = csWord(refUpc);
    check("R1/R2 uAddr", 32'(uAddr), 32'(refUpc));
    check("R3 pc", 32'(pc), 32'(refPc));
    check("R5/R6 mbr", 32'(mbr), 32'(refMbr));
    check("R7 uExec", 32'(uExec), 32'(refBoot == 0));
    expRd = (refBoot == 2) || (refBoot == 0 && w[11]);
    check("R4 memRd", 32'(memRd), 32'(expRd));
    if (expRd)
      check("R4 memAddr", 32'(memAddr),
            32'((refBoot == 2) ? 16'd0 : (w[10] ? refPc + 16'd1 : refPc)));
    if (refBoot == 0 && execIdx < 9) begin
      check("R8 sequence", 32'(uAddr), 32'(seqExp[execIdx]));
      execIdx++;
    end
  endtask

  task automatic refStep();
    logic [11:0] w;
    logic        reqV;
    logic [15:0] reqA;
    w = csWord(refUpc);
    reqV = 1'b0; reqA = '0;
    if (refReqV) refMbr = memByte(refReqA);
    if (refBoot == 2) begin
      reqV = 1'b1; refBoot = 1;
    end else if (refBoot == 1) begin
      refBoot = 0;
    end else begin
      if (w[11]) begin reqV = 1'b1; reqA = w[10] ? refPc + 16'd1 : refPc; end
      if (w[10]) refPc = refPc + 16'd1;
      refUpc = w[9] ? (w[8:0] | {1'b0, refMbr_prev}) : w[8:0];
    end
    refReqV = reqV; refReqA = reqA;
  endtask

  // Held copy of mbr from the start of the step, used for dispatch targets (R2)
  logic [7:0] refMbr_prev;

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      compare();
      refMbr_prev = refMbr;
      refStep();
      @(negedge clk);
    end
  endtask

  initial begin
    seqExp[0] = 9'h100; seqExp[1] = 9'h000; seqExp[2] = 9'h100;
    seqExp[3] = 9'h060; seqExp[4] = 9'h1B1; seqExp[5] = 9'h1B2;
    seqExp[6] = 9'h100; seqExp[7] = 9'h000; seqExp[8] = 9'h100;
    refReset();
    refMbr_prev = '0;
    rstN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 reset uAddr", 32'(uAddr), 32'(MAIN));
      check("R7 reset pc", 32'(pc), 32'd0);
      check("R7 reset uExec", 32'(uExec), 32'd0);
      check("R7 reset memRd", 32'(memRd), 32'd1);
      check("R7 reset memAddr", 32'(memAddr), 32'd0);
    end
    rstN = 1'b1;
    runCycles(3000);
    // Reset in mid-run, then the program must restart from scratch
    rstN = 1'b0;
    @(negedge clk);
    check("R7 rerun uAddr", 32'(uAddr), 32'(MAIN));
    check("R7 rerun pc", 32'(pc), 32'd0);
    check("R7 rerun uExec", 32'(uExec), 32'd0);
    refReset();
    rstN = 1'b1;
    runCycles(200);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule